// File: doc/BRIEF.md
# Match Channel Bank with Shared and Private Counters

The block is a bank of eight timer channels, numbered 4 to 11. Each channel holds a counter, a compare value and a control word. On every tick of its chosen clock source, a channel either advances its own counter or follows the counter of its group leader. When the value that the counter reaches equals the compare value, the channel raises a match event. The control word sets whether the counter clears on a match and whether matches repeat.

Software reaches the bank through a simple word-addressed register bus. Writes take effect at the clock edge. Reads return data combinationally in the same cycle. Eight tick-enable inputs carry the clock sources, and the logic that generates them sits outside the bank. Channels 9 and 11 can copy the counter of their pair leader (channel 8 or 10) into a snapshot register when software reads their own counter. Match events from all channels set sticky status bits, and those bits drive one shared interrupt line.

Register map, by word address (`bus_addr_i`); index k = channel − 4:
- k: compare value
- 8+k: counter
- 16+k: control word
- 24: status
- 25: enable
- 26: snapshot

Top module: `mcb_bank`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is low, and addresses 27 to 31 read 0.
- R2: Control bits [2:0] choose tick source s. A running counter adds 1 on each cycle in which `tick_en_i[s]` is high. With s = 0 the counter holds and the channel never matches.
- R3: When control bit 7 is set, the channel uses its own counter. When bit 7 is clear:
  - channels 4–7 compare against channel 4's counter;
  - channels 8–9 compare against channel 8's counter;
  - channels 10–11 compare against channel 10's counter;
  - the channel's own counter does not run, unless the channel is itself a group leader.
- R4: A match happens when the referenced counter ticks to a value equal to the channel's compare value. It sets status bit 4+k in the cycle after the tick, but only if enable bit 4+k is set.
- R5: With control bit 3 set, a match loads the channel's own counter with 0 instead of the matched value.
- R6: With control bit 6 clear, a channel matches once only. It is re-armed by a write to its compare value or to its control word. With bit 6 set, every match counts.
- R7: Channels 4–7 keep control bits [7:0], so bits [9:8] read 0. Channels 8–11 keep bits [9:0]. On channels 8–11, bit 8 stops the counter whatever the value of bits [2:0].
- R8: A read of channel 9's or channel 11's counter captures the current count of channel 8 or 10 into the snapshot register, if bit 9 of the reader's control word is set. The snapshot register cannot be written and keeps its value until the next capture.
- R9: Writing 1 to a status bit clears it; a new match in the same cycle wins. `irq_o` is high while any status bit [11:4] is set.
- R10: A write to a counter loads it in the next cycle. The write takes priority over a tick in the same cycle.
- R11: A new control word governs ticks only from the cycle after its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_en_i | input | 8 | Per-source tick enables |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 5 | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data (combinational) |
| irq_o | output | 1 | Shared interrupt |

## Verification
Every register effect has a latency of one cycle, measured from the rising edge that samples a write strobe or a tick. This covers counter values, status bits, the snapshot and `irq_o`. Read data is combinational from the current state.

The bench drives all inputs at falling edges. It samples read data a nanosecond later, before the next rising edge. Each register task therefore returns on the falling edge that follows the commit, so every readback lands exactly one cycle after its stimulus. Tick bursts of n cycles are checked as exactly n increments.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
    localparam int NCH    = 8;
    localparam int NSRC   = 8;
    localparam int SRC_W  = $clog2(NSRC);
    localparam int CTRL_W = 10;
    localparam int ST_LSB = 4;

    // control-word bit positions
    localparam int B_CLR  = 3;
    localparam int B_PER  = 6;
    localparam int B_OWN  = 7;
    localparam int B_STOP = 8;
    localparam int B_SNAP = 9;

    // address groups: bus_addr[4:3]
    localparam logic [1:0] G_MATCH = 2'd0;
    localparam logic [1:0] G_CNT   = 2'd1;
    localparam logic [1:0] G_CTRL  = 2'd2;
    localparam logic [1:0] G_MISC  = 2'd3;

    localparam logic [2:0] M_STS  = 3'd0;
    localparam logic [2:0] M_ENA  = 3'd1;
    localparam logic [2:0] M_SNAP = 3'd2;

    // group leader of channel index k (channel k+4)
    function automatic int leader_of(input int k);
        if (k < 4) return 0;
        else if (k < 6) return 4;
        else return 6;
    endfunction
endpackage

// File: rtl/mcb_src_sel.sv
module mcb_src_sel
    import mcb_pkg::*;
#(
    parameter bit IS_LEADER = 1'b0,
    parameter bit HAS_STOP  = 1'b0
) (
    input  logic [SRC_W-1:0] src_i,
    input  logic             own_i,
    input  logic             stop_i,
    input  logic [NSRC-1:0]  tick_en_i,
    output logic             tick_o
);
    logic [SRC_W-1:0] src_eff;
    logic             runs;

    always_comb begin
        src_eff = (HAS_STOP && stop_i) ? '0 : src_i;
        runs    = (own_i || IS_LEADER) && (src_eff != '0);
        tick_o  = runs && tick_en_i[src_eff];
    end
endmodule

// File: rtl/mcb_rd_mux.sv
module mcb_rd_mux
    import mcb_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic [1:0]                   grp_i,
    input  logic [2:0]                   idx_i,
    input  logic [NCH-1:0][CNT_W-1:0]    mat_i,
    input  logic [NCH-1:0][CNT_W-1:0]    cnt_i,
    input  logic [NCH-1:0][CTRL_W-1:0]   ctl_i,
    input  logic [NCH-1:0]               sts_i,
    input  logic [NCH-1:0]               ena_i,
    input  logic [CNT_W-1:0]             snap_i,
    output logic [DATA_W-1:0]            rdata_o
);
    always_comb begin
        rdata_o = '0;
        unique case (grp_i)
            G_MATCH: rdata_o = DATA_W'(mat_i[idx_i]);
            G_CNT:   rdata_o = DATA_W'(cnt_i[idx_i]);
            G_CTRL:  rdata_o = DATA_W'(ctl_i[idx_i]);
            default: begin
                if (idx_i == M_STS)       rdata_o = DATA_W'(sts_i) << ST_LSB;
                else if (idx_i == M_ENA)  rdata_o = DATA_W'(ena_i) << ST_LSB;
                else if (idx_i == M_SNAP) rdata_o = DATA_W'(snap_i);
            end
        endcase
    end
endmodule

// File: rtl/mcb_bank.sv
module mcb_bank
    import mcb_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   tick_en_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [4:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam logic [CTRL_W-1:0] NARROW_MASK = CTRL_W'(10'h0FF);
    localparam logic [CTRL_W-1:0] WIDE_MASK   = CTRL_W'(10'h3FF);

    typedef struct packed {
        logic [NCH-1:0][CNT_W-1:0]  mat;
        logic [NCH-1:0][CNT_W-1:0]  cnt;
        logic [NCH-1:0][CTRL_W-1:0] ctl;
        logic [NCH-1:0]             fired;
        logic [NCH-1:0]             sts;
        logic [NCH-1:0]             ena;
        logic [CNT_W-1:0]           snap;
    } state_t;

    state_t s_q, s_d;

    logic [1:0]     grp;
    logic [2:0]     idx;
    logic [NCH-1:0] tick;

    assign grp = bus_addr_i[4:3];
    assign idx = bus_addr_i[2:0];

    for (genvar k = 0; k < NCH; k++) begin : g_src
        mcb_src_sel #(
            .IS_LEADER(k == leader_of(k)),
            .HAS_STOP (k >= NCH/2)
        ) u_src (
            .src_i    (s_q.ctl[k][SRC_W-1:0]),
            .own_i    (s_q.ctl[k][B_OWN]),
            .stop_i   (s_q.ctl[k][B_STOP]),
            .tick_en_i(tick_en_i),
            .tick_o   (tick[k])
        );
    end

    always_comb begin
        logic [NCH-1:0][CNT_W-1:0] inc;
        logic [NCH-1:0]            evt;
        logic                      wsel;
        int                        r;

        s_d = s_q;
        for (int k = 0; k < NCH; k++) inc[k] = s_q.cnt[k] + CNT_W'(1);

        for (int k = 0; k < NCH; k++) begin
            r      = s_q.ctl[k][B_OWN] ? k : leader_of(k);
            evt[k] = tick[r] && (inc[r] == s_q.mat[k])
                     && (s_q.ctl[k][B_PER] || !s_q.fired[k]);
        end

        for (int k = 0; k < NCH; k++) begin
            wsel = bus_wr_i && (idx == 3'(k));
            // tick implies the channel runs on its own counter
            if (tick[k])
                s_d.cnt[k] = (evt[k] && s_q.ctl[k][B_CLR]) ? '0 : inc[k];
            if (evt[k]) s_d.fired[k] = 1'b1;
            if (wsel && grp == G_CNT) s_d.cnt[k] = bus_wdata_i[CNT_W-1:0];
            if (wsel && grp == G_MATCH) begin
                s_d.mat[k]   = bus_wdata_i[CNT_W-1:0];
                s_d.fired[k] = 1'b0;
            end
            if (wsel && grp == G_CTRL) begin
                s_d.ctl[k]   = bus_wdata_i[CTRL_W-1:0]
                               & ((k >= NCH/2) ? WIDE_MASK : NARROW_MASK);
                s_d.fired[k] = 1'b0;
            end
        end

        s_d.sts = s_q.sts;
        if (bus_wr_i && grp == G_MISC && idx == M_STS)
            s_d.sts = s_q.sts & ~bus_wdata_i[ST_LSB +: NCH];
        s_d.sts = s_d.sts | (evt & s_q.ena);

        if (bus_wr_i && grp == G_MISC && idx == M_ENA)
            s_d.ena = bus_wdata_i[ST_LSB +: NCH];

        if (bus_rd_i && grp == G_CNT && (idx == 3'd5 || idx == 3'd7)
            && s_q.ctl[idx][B_SNAP])
            s_d.snap = s_q.cnt[idx - 3'd1];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    mcb_rd_mux #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
        .grp_i  (grp),
        .idx_i  (idx),
        .mat_i  (s_q.mat),
        .cnt_i  (s_q.cnt),
        .ctl_i  (s_q.ctl),
        .sts_i  (s_q.sts),
        .ena_i  (s_q.ena),
        .snap_i (s_q.snap),
        .rdata_o(bus_rdata_o)
    );

    assign irq_o = |s_q.sts;
endmodule

// File: rtl/mcb_bank_chk.sv
module mcb_bank_chk #(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [7:0]        tick_en_i,
    input logic              bus_wr_i,
    input logic              bus_rd_i,
    input logic [4:0]        bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              irq_o,
    input logic [CNT_W-1:0]  cnt0_i,
    input logic [2:0]        src0_i,
    input logic [CNT_W-1:0]  snap_i
);
    AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src0_i == 3'd0 && !(bus_wr_i && bus_addr_i == 5'd8)) |=> $stable(cnt0_i)); // R2

    AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == 5'd8) |=> (cnt0_i == $past(bus_wdata_i[CNT_W-1:0]))); // R10

    AST_SNAP_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_rd_i && (bus_addr_i == 5'd13 || bus_addr_i == 5'd15)) |=> $stable(snap_i)); // R8

    AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !bus_wr_i) |=> irq_o); // R9

    AST_IRQ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == 5'd24 && (&bus_wdata_i[11:4]) && tick_en_i == 8'd0)
        |=> !irq_o); // R9
endmodule

bind mcb_bank mcb_bank_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_en_i  (tick_en_i),
    .bus_wr_i   (bus_wr_i),
    .bus_rd_i   (bus_rd_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .irq_o      (irq_o),
    .cnt0_i     (s_q.cnt[0]),
    .src0_i     (s_q.ctl[0][2:0]),
    .snap_i     (s_q.snap)
);

// File: tb/mcb_bank_tb.sv
module mcb_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tick_en = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mcb_bank dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en),
        .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic run(input logic [7:0] m, input int n);
        tick_en = m;
        repeat (n) @(negedge clk);
        tick_en = '0;
    endtask

    task automatic clr_all();
        for (int k = 0; k < 8; k++) begin
            wr(5'(16 + k), 0); wr(5'(8 + k), 0); wr(5'(k), 0);
        end
        wr(25, 0);
        wr(24, 32'hFF0);
    endtask

    function automatic int leader(input int k);
        return (k < 4) ? 0 : ((k < 6) ? 4 : 6);
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state over the whole map
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), v); chk("R1 reset read", v, 0);
        end
        chk("R1 irq after reset", {31'd0, irq}, 0);

        // R2 source sweep on channel 4, own counter
        for (int s = 0; s < 8; s++) begin
            clr_all();
            wr(16, 32'h80 | s);
            run(~(8'd1 << s), 3);
            run(8'd1 << s, 5);
            rd(8, v); chk("R2 tick source count", v, (s == 0) ? 0 : 5);
        end

        // R10 write beats tick
        clr_all();
        wr(16, 32'h81);
        tick_en = 8'h02;
        wr(8, 100);
        tick_en = 8'h00;
        rd(8, v); chk("R10 load over tick", v, 100);

        // R11 control effective from next cycle
        clr_all();
        tick_en = 8'hFF;
        wr(16, 32'h81);
        tick_en = 8'h00;
        rd(8, v); chk("R11 no tick in write cycle", v, 0);
        run(8'h02, 1);
        rd(8, v); chk("R11 tick after write", v, 1);

        // R3/R4 group leader sweep
        for (int k = 0; k < 8; k++) begin
            clr_all();
            wr(5'(16 + leader(k)), 32'h1);
            wr(5'(k), 4);
            wr(25, 32'hFF0);
            run(8'h02, 4);
            rd(24, v); chk("R3 R4 leader match status", v, 32'h10 << k);
            chk("R4 irq on match", {31'd0, irq}, 1);
            rd(5'(8 + leader(k)), v); chk("R3 leader count", v, 4);
            if (k != leader(k)) begin
                rd(5'(8 + k), v); chk("R3 follower idle", v, 0);
            end
        end

        // R4 enable gates status
        clr_all();
        wr(16, 32'h81); wr(0, 2);
        run(8'h02, 2);
        rd(24, v); chk("R4 disabled no status", v, 0);

        // R5 clear on match, periodic
        clr_all();
        wr(16, 32'hC9); wr(0, 3); wr(25, 32'hFF0);
        run(8'h02, 3);
        rd(8, v);  chk("R5 counter cleared", v, 0);
        rd(24, v); chk("R5 status", v, 32'h10);
        wr(24, 32'hFF0);
        run(8'h02, 3);
        rd(24, v); chk("R6 periodic rematch", v, 32'h10);
        rd(8, v);  chk("R5 cleared again", v, 0);

        // R6 one-shot
        clr_all();
        wr(16, 32'h89); wr(0, 2); wr(25, 32'hFF0);
        run(8'h02, 2);
        rd(24, v); chk("R6 first match", v, 32'h10);
        wr(24, 32'hFF0);
        run(8'h02, 2);
        rd(24, v); chk("R6 one-shot silent", v, 0);
        rd(8, v);  chk("R6 no clear when silent", v, 2);
        wr(8, 0); wr(0, 2);
        run(8'h02, 2);
        rd(24, v); chk("R6 rearmed by compare write", v, 32'h10);

        // R7 control widths and stop bit
        clr_all();
        wr(16, 32'h3FF); rd(16, v); chk("R7 narrow control", v, 32'hFF);
        wr(20, 32'h3FF); rd(20, v); chk("R7 wide control", v, 32'h3FF);
        clr_all();
        wr(20, 32'h181);
        run(8'hFF, 4);
        rd(12, v); chk("R7 stop bit holds", v, 0);
        wr(20, 32'h081);
        run(8'h02, 4);
        rd(12, v); chk("R7 runs without stop", v, 4);

        // R8 snapshot
        clr_all();
        wr(20, 32'h81);
        run(8'h02, 5);
        wr(21, 32'h200);
        rd(13, v); chk("R8 reader own count", v, 0);
        rd(26, v); chk("R8 capture ch8", v, 5);
        run(8'h02, 3);
        rd(26, v); chk("R8 holds", v, 5);
        wr(21, 0);
        rd(13, v);
        rd(26, v); chk("R8 no capture without bit9", v, 5);
        wr(22, 32'h81);
        run(8'h02, 7);
        wr(23, 32'h200);
        rd(15, v);
        rd(26, v); chk("R8 capture ch10", v, 7);
        wr(26, 32'hDEAD);
        rd(26, v); chk("R8 read-only", v, 7);

        // R9 status clear and shared irq
        clr_all();
        wr(16, 32'h81); wr(17, 32'h00); wr(18, 32'h00);
        wr(0, 2); wr(1, 2); wr(2, 2);
        wr(25, 32'h050);
        run(8'h02, 2);
        rd(24, v); chk("R9 status set", v, 32'h050);
        wr(24, 32'h010);
        chk("R9 irq stays", {31'd0, irq}, 1);
        rd(24, v); chk("R9 partial clear", v, 32'h040);
        wr(24, 32'h040);
        chk("R9 irq drops", {31'd0, irq}, 0);

        finish_run();
    end
endmodule